// File: doc/BRIEF.md
# Bubble-Tolerant Cyclic Thermometer Encoder

This block sits behind the fine and coarse comparator banks of a folding converter and turns their raw bits into one binary output word. The fine bank produces a cyclic thermometer pattern. In that pattern the bit past the top end reads as the inverse of bit 0, so every legal pattern has exactly one transition. The block finds that transition with three-bit windows. The windows are sampled into a register only on the same strobe that moves the pipeline, so detection and latching happen in one stage. A lookup-style encoder then reduces the one-hot result to a fine code. The coarse bank's ones are counted to give the fold number. On odd folds the fine code is mirrored, so the combined word rises monotonically with the input.

Samples enter and leave on valid/ready handshakes. A sample transfers when valid and ready are both high at a rising edge. The whole pipeline advances together. `in_ready` equals `!out_valid || out_ready`, which is a combinational path from `out_ready`. While an output waits with `out_ready` low, the output word stays frozen, no new sample is accepted and no sample in flight is lost.

Top module: `cyc_therm_enc`

## Requirements
- R1: For a clean fine pattern of code k, the fine field `out_word[5:0]` on an even fold equals k. For k in 0..31 the pattern sets bit j exactly when j <= k, so all ones gives 31. For k in 32..63 the pattern sets bit j exactly when j > k-32, so all zeros gives 63.
- R2: The fold field `out_word[8:6]` equals the number of ones among the six coarse bits, whatever their positions.
- R3: When the fold is odd, the fine field is the bitwise inverse of the fine code.
- R4: A single wrong bit placed two positions past the transition leaves the code unchanged and `out_err` low. For a falling transition this is a 1 at bit k+2 for code k < 32. For a rising transition it is a 0 at bit (k-32)+2 for code k >= 32.
- R5: If the windows flag no position, or more than one, `out_err` is 1. The fine code used is then the last one produced with `out_err` low, or 0 if there was none since reset. The current fold and the R3 inversion still apply.
- R6: With `out_ready` held high, a sample accepted at a rising edge appears with `out_valid` high after the third rising edge, counting the accepting edge as the first.
- R7: While `out_valid` is high and `out_ready` is low, `out_word` and `out_err` hold, `in_ready` is low, and every accepted sample still comes out once and in order.
- R8: With `out_ready` high, one sample is accepted on every cycle and the outputs come out in acceptance order.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, `out_word` is 0 and `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered on fine_in and coarse_in |
| in_ready | output | 1 | The block accepts a sample at this edge |
| fine_in | input | 32 | Fine comparator bits, cyclic thermometer |
| coarse_in | input | 6 | Coarse comparator bits |
| out_valid | output | 1 | out_word and out_err carry a result |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_word | output | 9 | Fold in bits 8:6, fine field in bits 5:0 |
| out_err | output | 1 | The fine pattern had no single transition |

## Verification
The error-hold property rebuilds the last good fine code from accepted outputs. It relies on every produced result being taken before the next one appears, which the single-advance pipeline guarantees. The fold-range property assumes the coarse field can only be a count of six bits. The stimulus holds each sample steady until it is accepted and changes inputs only between edges. It places every deliberate bubble well away from the wrap point, so that each pattern's expected outcome follows directly from R4 and R5.

// File: rtl/cte_pkg.sv
package cte_pkg;

  // population count of a bit vector padded to 64 bits
  function automatic int unsigned cte_ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 64; k++) n = n + 32'(v[k]);
    return n;
  endfunction

endpackage

// File: rtl/cte_edge_detect.sv
module cte_edge_detect #(
  parameter int FINE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe,
  input  logic [FINE_W-1:0]     therm,
  output logic [2*FINE_W-1:0]   hot
);
  logic [FINE_W-1:0] fall_w;
  logic [FINE_W-1:0] rise_w;

  for (genvar gi = 0; gi < FINE_W; gi++) begin : g_win
    logic lft, rgt;
    // neighbours past either end read the inverted opposite end
    if (gi == 0) begin : g_lo
      assign lft = ~therm[FINE_W-1];
    end else begin : g_lo
      assign lft = therm[gi-1];
    end
    if (gi == FINE_W-1) begin : g_hi
      assign rgt = ~therm[0];
    end else begin : g_hi
      assign rgt = therm[gi+1];
    end
    // the strobe is the fourth term of each window: capture only on advance
    assign fall_w[gi] = strobe &  lft &  therm[gi] & ~rgt;
    assign rise_w[gi] = strobe & ~lft & ~therm[gi] &  rgt;
  end

  always_ff @(posedge clk) begin
    if (rst)         hot <= '0;
    else if (strobe) hot <= {rise_w, fall_w};
  end
endmodule

// File: rtl/cte_onehot_rom.sv
module cte_onehot_rom #(
  parameter int HOT_W   = 64,
  parameter int FCODE_W = 6
) (
  input  logic [HOT_W-1:0]   hot,
  output logic [FCODE_W-1:0] code,
  output logic               bad
);
  logic seen, multi;

  // each set line ORs its own index into the code, as a ROM row would
  always_comb begin
    code  = '0;
    seen  = 1'b0;
    multi = 1'b0;
    for (int j = 0; j < HOT_W; j++) begin
      if (hot[j]) begin
        code  = code | FCODE_W'(j);
        multi = multi | seen;
        seen  = 1'b1;
      end
    end
    bad = multi | ~seen;
  end
endmodule

// File: rtl/cte_fold_merge.sv
module cte_fold_merge #(
  parameter int FCODE_W = 6,
  parameter int FOLD_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       strobe,
  input  logic                       vld_in,
  input  logic [FOLD_W-1:0]          fold,
  input  logic [FCODE_W-1:0]         code,
  input  logic                       bad,
  output logic                       vld_out,
  output logic [FOLD_W+FCODE_W-1:0]  word,
  output logic                       err
);
  logic [FCODE_W-1:0] last_good;
  logic [FCODE_W-1:0] use_code;
  logic [FCODE_W-1:0] fine_adj;

  assign use_code = bad ? last_good : code;
  assign fine_adj = fold[0] ? ~use_code : use_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_good <= '0;
      word      <= '0;
      err       <= 1'b0;
      vld_out   <= 1'b0;
    end else if (strobe) begin
      vld_out <= vld_in;
      if (vld_in) begin
        word <= {fold, fine_adj};
        err  <= bad;
        if (!bad) last_good <= code;
      end
    end
  end
endmodule

// File: rtl/cyc_therm_enc.sv
module cyc_therm_enc #(
  parameter int FINE_W   = 32,
  parameter int COARSE_W = 6
) (
  input  logic                                                          clk,
  input  logic                                                          rst,
  input  logic                                                          in_valid,
  output logic                                                          in_ready,
  input  logic [FINE_W-1:0]                                             fine_in,
  input  logic [COARSE_W-1:0]                                           coarse_in,
  output logic                                                          out_valid,
  input  logic                                                          out_ready,
  output logic [$clog2(COARSE_W+1)+$clog2(2*FINE_W)-1:0]                out_word,
  output logic                                                          out_err
);
  import cte_pkg::*;

  localparam int HOT_W   = 2 * FINE_W;
  localparam int FCODE_W = $clog2(HOT_W);
  localparam int FOLD_W  = $clog2(COARSE_W + 1);

  logic                  adv;
  logic                  v1, v2;
  logic [FINE_W-1:0]     fine_q;
  logic [COARSE_W-1:0]   coarse_q;
  logic [FOLD_W-1:0]     fold_q;
  logic [HOT_W-1:0]      hot_q;
  logic [FCODE_W-1:0]    code_c;
  logic                  bad_c;

  // one advance for every stage keeps both paths at equal depth
  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      v2       <= 1'b0;
      fine_q   <= '0;
      coarse_q <= '0;
      fold_q   <= '0;
    end else if (adv) begin
      v1       <= in_valid;
      v2       <= v1;
      fine_q   <= fine_in;
      coarse_q <= coarse_in;
      fold_q   <= FOLD_W'(cte_ones({{(64-COARSE_W){1'b0}}, coarse_q}));
    end
  end

  cte_edge_detect #(.FINE_W(FINE_W)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .strobe (adv),
    .therm  (fine_q),
    .hot    (hot_q)
  );

  cte_onehot_rom #(.HOT_W(HOT_W), .FCODE_W(FCODE_W)) u_rom (
    .hot  (hot_q),
    .code (code_c),
    .bad  (bad_c)
  );

  cte_fold_merge #(.FCODE_W(FCODE_W), .FOLD_W(FOLD_W)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .strobe  (adv),
    .vld_in  (v2),
    .fold    (fold_q),
    .code    (code_c),
    .bad     (bad_c),
    .vld_out (out_valid),
    .word    (out_word),
    .err     (out_err)
  );
endmodule

// File: rtl/cte_checks.sv
module cte_checks #(
  parameter int FINE_W   = 32,
  parameter int COARSE_W = 6
) (
  input logic                                            clk,
  input logic                                            rst,
  input logic                                            in_ready,
  input logic                                            out_valid,
  input logic                                            out_ready,
  input logic [$clog2(COARSE_W+1)+$clog2(2*FINE_W)-1:0]  out_word,
  input logic                                            out_err
);
  localparam int FCODE_W = $clog2(2 * FINE_W);
  localparam int FOLD_W  = $clog2(COARSE_W + 1);
  localparam int OUT_W   = FOLD_W + FCODE_W;

  logic [FCODE_W-1:0] rec_fine;
  logic [FCODE_W-1:0] last_ok;

  assign rec_fine = out_word[FCODE_W-1:0] ^ {FCODE_W{out_word[FCODE_W]}};

  always_ff @(posedge clk) begin
    if (rst) last_ok <= '0;
    else if (out_valid && out_ready && !out_err) last_ok <= rec_fine;
  end

  // R7: a waiting result is frozen
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_err));

  // R7: no intake while the output waits
  a_r7_no_intake: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R2: fold never exceeds the coarse bit count
  a_r2_fold_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[OUT_W-1:FCODE_W] <= FOLD_W'(COARSE_W));

  // R5: an error result reuses the last good fine code
  a_r5_err_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> rec_fine == last_ok);
endmodule

bind cyc_therm_enc cte_checks #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_err   (out_err)
);

// File: tb/cyc_therm_enc_test.sv
module cyc_therm_enc_test;
  localparam int CLK_P = 10;
  localparam int FW = 32;
  localparam int CW = 6;
  localparam int OW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [FW-1:0] fine_in = '0;
  logic [CW-1:0] coarse_in = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [OW-1:0] out_word;
  logic          out_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [5:0] last_good = '0;

  logic [OW-1:0] q_word[$];
  logic          q_err[$];
  string         q_tag[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cyc_therm_enc uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .fine_in(fine_in), .coarse_in(coarse_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // output monitor: sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      checks++;
      if (q_word.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected output actual=%h expected=none", out_word);
      end else begin
        logic [OW-1:0] ew;
        logic ee;
        string tg;
        ew = q_word.pop_front();
        ee = q_err.pop_front();
        tg = q_tag.pop_front();
        if (out_word !== ew || out_err !== ee) begin
          failures++;
          $display("FAIL %s actual=%h/%b expected=%h/%b", tg, out_word, out_err, ew, ee);
        end
      end
    end
  end

  function automatic logic [FW-1:0] pat(input int v);
    logic [FW-1:0] t;
    for (int j = 0; j < FW; j++) t[j] = (v < FW) ? (j <= v) : (j > v - FW);
    return t;
  endfunction

  // called at posedge+1; returns at posedge+1 after the accepting edge
  task automatic xmit(input logic [FW-1:0] f, input logic [CW-1:0] c,
                      input int code, input bit bad, input string tag);
    bit acc;
    logic [2:0] fold;
    logic [5:0] fc;
    fold = 3'($countones(c));
    fc = bad ? last_good : 6'(code);
    if (!bad) last_good = 6'(code);
    in_valid = 1'b1; fine_in = f; coarse_in = c;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      if (in_ready) acc = 1'b1;
      else begin @(posedge clk); #1; end
    end
    q_word.push_back({fold, fold[0] ? ~fc : fc});
    q_err.push_back(bad);
    q_tag.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_word.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    chk(out_word == '0, "R9 out_word", out_word, 0);
    chk(out_err == 1'b0, "R9 out_err", out_err, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 2 * FW; v++) xmit(pat(v), 6'b000000, v, 1'b0, "R1 sweep");
    drain();
  endtask

  task automatic t_folds();
    xmit(pat(10), 6'b000001, 10, 1'b0, "R3 fold1 inverted");
    xmit(pat(40), 6'b100110, 40, 1'b0, "R2 R3 fold3 scattered");
    xmit(pat(63), 6'b111111, 63, 1'b0, "R2 fold6");
    xmit(pat(31), 6'b010100, 31, 1'b0, "R2 fold2 wrap");
    xmit(pat(0), 6'b011111, 0, 1'b0, "R3 fold5");
    drain();
  endtask

  task automatic t_bubbles();
    logic [FW-1:0] t;
    t = pat(7);  t[9] = 1'b1;
    xmit(t, 6'b000011, 7, 1'b0, "R4 falling bubble");
    t = pat(44); t[14] = 1'b0;
    xmit(t, 6'b000111, 44, 1'b0, "R4 rising bubble");
    drain();
  endtask

  task automatic t_errors();
    logic [FW-1:0] t;
    xmit(pat(50), 6'b000000, 50, 1'b0, "R5 prime good");
    t = pat(5); t[20] = 1'b1;
    xmit(t, 6'b000011, 0, 1'b1, "R5 multi hold even");
    xmit(t, 6'b000001, 0, 1'b1, "R5 multi hold odd");
    xmit(pat(22), 6'b000000, 22, 1'b0, "R5 recover");
    drain();
  endtask

  task automatic t_latency();
    xmit(pat(3), 6'b000000, 3, 1'b0, "R6 value");
    @(negedge clk); chk(out_valid == 1'b0, "R6 edge1", out_valid, 0);
    @(negedge clk); chk(out_valid == 1'b0, "R6 edge2", out_valid, 0);
    @(negedge clk); chk(out_valid == 1'b1, "R6 edge3", out_valid, 1);
    drain();
  endtask

  task automatic t_stall();
    logic [OW-1:0] held;
    out_ready = 1'b0;
    xmit(pat(12), 6'b000001, 12, 1'b0, "R7 stall a");
    xmit(pat(13), 6'b000010, 13, 1'b0, "R7 stall b");
    xmit(pat(14), 6'b000000, 14, 1'b0, "R7 stall c");
    @(negedge clk);
    held = out_word;
    chk(out_valid == 1'b1, "R7 waiting valid", out_valid, 1);
    chk(held == {3'd1, ~6'd12}, "R7 waiting word", held, {3'd1, ~6'd12});
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_word == held, "R7 word held", out_word, held);
      chk(in_ready == 1'b0, "R7 intake blocked", in_ready, 0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    drain();
  endtask

  task automatic t_stream();
    int start;
    start = cyc;
    for (int k = 0; k < 10; k++) xmit(pat(k * 5), 6'(k % 7 == 6 ? 6'b111111 : 6'b000000), k * 5, 1'b0, "R8 stream");
    chk(cyc - start == 10, "R8 one per cycle", cyc - start, 10);
    drain();
  endtask

  task automatic t_toggle();
    fork
      begin
        for (int k = 0; k < 16; k++) xmit(pat(63 - k * 3), 6'(k), 63 - k * 3, 1'b0, "R7 toggled ready");
      end
      begin
        for (int k = 0; k < 40; k++) begin
          @(posedge clk); #1;
          out_ready = (k % 3) != 1;
        end
        out_ready = 1'b1;
      end
    join
    drain();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_sweep();
    t_folds();
    t_bubbles();
    t_errors();
    t_latency();
    t_stall();
    t_stream();
    t_toggle();
    repeat (4) @(posedge clk);
    chk(q_word.size() == 0, "R7 nothing lost", q_word.size(), 0);
    finish_run();
  end
endmodule